// File: doc/BRIEF.md
# Paging message codeword collector

This block gathers the message part of a paging transmission. A separate matcher finds a codeword that carries this receiver's address and sends a start pulse. The collector then takes each 32-bit codeword that arrives with a valid strobe. For every message codeword it stores the 20 data bits in a register and gives a one-cycle ready pulse. Error correction is done upstream; the collector receives its result as a corrected-bit count and an uncorrectable flag, and turns that result into a validity flag for the stored data.

Reception ends on the first codeword that is not a message codeword. This is an address codeword or the idle codeword. At that point a sticky done flag is raised. Once a message word has been judged bad, every later message word of the same message is dropped. Words that arrive in the synchronisation slot of a batch are skipped and do not end the message.

Top module: `pgmc_collect`

## Requirements
- R1: While reset is low and on the first cycle after it, `msg_data_o`, `msg_rdy_o`, `msg_err_o` and `done_o` are all 0, and no collection is active.
- R2: Before the first start pulse, and after reception has ended, strobed codewords have no effect. No ready pulse appears, and data, error and done keep their values.
- R3: While collecting, a strobed word in a normal slot with bit 31 = 1 is a message word. Its bits 30 down to 11 (bit 30 becomes `msg_data_o[19]`) appear on `msg_data_o`, and `msg_rdy_o` is high for exactly the one cycle after the strobe cycle.
- R4: With each stored word, `msg_err_o` becomes 0 when `uncorr_i` is 0 and `err_cnt_i` is at most 2. It becomes 1 when `uncorr_i` is 1 or `err_cnt_i` is 3 or more.
- R5: After a word has been stored with `msg_err_o` = 1, later message words produce no ready pulse and leave data and error unchanged, until the next start pulse.
- R6: While collecting, a strobed word in a normal slot with bit 31 = 0 ends reception. This covers any address word and the idle word 32'h7A89C197. `done_o` goes to 1 in the cycle after the strobe and stays at 1.
- R7: A strobed word with `sync_slot_i` = 1 has no effect, whatever its content, and does not end reception.
- R8: A start pulse clears `done_o` and `msg_err_o` and begins a new collection. A codeword strobed in the same cycle as the start pulse is ignored.
- R9: Cycles with `cw_valid_i` = 0 have no effect, whatever `cw_i` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle pulse from the address matcher |
| cw_valid_i | input | 1 | Codeword strobe |
| cw_i | input | 32 | Codeword after error correction |
| sync_slot_i | input | 1 | The strobed word sits in the batch synchronisation slot |
| err_cnt_i | input | 3 | Number of bit errors corrected in this word |
| uncorr_i | input | 1 | The error checker could not correct this word |
| msg_data_o | output | 20 | Last stored message bits |
| msg_rdy_o | output | 1 | One-cycle pulse per stored message word |
| msg_err_o | output | 1 | The stored message bits are invalid |
| done_o | output | 1 | Reception ended on an address or idle word |

## Verification
The internal state is a collecting flag and the error lock. If the collecting flag is wrong, it shows at the ports on the next strobed word. An extra or missing ready pulse appears one cycle after that strobe, or `done_o` moves when it should not. If the error lock is wrong, the next message word after a bad one gives a ready pulse with new data. The bench applies every stimulus to a behavioural model and compares all four outputs on every cycle, so any such fault is reported in the cycle where it first becomes visible.

// File: rtl/pgmc_pkg.sv
package pgmc_pkg;

   typedef enum logic [2:0] {
      CWK_NONE = 3'd0,
      CWK_SKIP = 3'd1,
      CWK_MSG  = 3'd2,
      CWK_ADDR = 3'd3,
      CWK_IDLE = 3'd4
   } cw_kind_t;

   typedef enum logic {
      ST_OFF     = 1'b0,
      ST_COLLECT = 1'b1
   } ctrl_state_t;

endpackage

// File: rtl/pgmc_classify.sv
module pgmc_classify
   import pgmc_pkg::*;
#(
   parameter int          CW_W       = 32,
   parameter int          FLAG_BIT   = 31,
   parameter logic [31:0] IDLE_WORD  = 32'h7A89C197,
   parameter bit          IDLE_EXACT = 1'b1
) (
   input  logic            valid_i,
   input  logic            sync_i,
   input  logic [CW_W-1:0] cw_i,
   output cw_kind_t        kind_o
);

   logic is_idle;

   generate
      if (IDLE_EXACT) begin : g_idle_cmp
         assign is_idle = (cw_i == IDLE_WORD[CW_W-1:0]);
      end else begin : g_idle_none
         // the idle word has flag bit 0, so it is still treated as an address word
         assign is_idle = 1'b0;
      end
   endgenerate

   always_comb begin
      if (!valid_i)            kind_o = CWK_NONE;
      else if (sync_i)         kind_o = CWK_SKIP;
      else if (cw_i[FLAG_BIT]) kind_o = CWK_MSG;
      else if (is_idle)        kind_o = CWK_IDLE;
      else                     kind_o = CWK_ADDR;
   end

endmodule

// File: rtl/pgmc_err_judge.sv
module pgmc_err_judge #(
   parameter int ERR_CNT_W = 3,
   parameter int MAX_FIX   = 2
) (
   input  logic [ERR_CNT_W-1:0] cnt_i,
   input  logic                 uncorr_i,
   output logic                 bad_o
);

   localparam logic [ERR_CNT_W-1:0] LIMIT = ERR_CNT_W'(MAX_FIX);

   generate
      if (MAX_FIX == 0) begin : g_zero_tol
         assign bad_o = uncorr_i | (|cnt_i);
      end else begin : g_limit
         assign bad_o = uncorr_i | (cnt_i > LIMIT);
      end
   endgenerate

   always_comb begin
      AST_UNCORR_IS_BAD : assert (!uncorr_i || bad_o); // R4
   end

endmodule

// File: rtl/pgmc_ctrl.sv
module pgmc_ctrl
   import pgmc_pkg::*;
#(
   parameter int DATA_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  cw_kind_t          kind_i,
   input  logic              bad_i,
   input  logic [DATA_W-1:0] field_i,
   output logic [DATA_W-1:0] data_o,
   output logic              rdy_o,
   output logic              err_o,
   output logic              done_o
);

   ctrl_state_t       st_q;
   logic [DATA_W-1:0] data_q;
   logic              rdy_q, err_q, done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_OFF;
         data_q <= '0;
         rdy_q  <= 1'b0;
         err_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         rdy_q <= 1'b0;
         if (start_i) begin
            st_q   <= ST_COLLECT;
            err_q  <= 1'b0;
            done_q <= 1'b0;
         end else if (st_q == ST_COLLECT) begin
            case (kind_i)
               CWK_MSG: begin
                  if (!err_q) begin
                     data_q <= field_i;
                     rdy_q  <= 1'b1;
                     err_q  <= bad_i;
                  end
               end
               CWK_ADDR, CWK_IDLE: begin
                  done_q <= 1'b1;
                  st_q   <= ST_OFF;
               end
               default: ;
            endcase
         end
      end
   end

   assign data_o = data_q;
   assign rdy_o  = rdy_q;
   assign err_o  = err_q;
   assign done_o = done_q;

   AST_OFF_NO_RDY : assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_OFF && !start_i) |=> !rdy_q); // R2
   AST_ERR_LOCKS : assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !start_i) |=> (!rdy_q && $stable(data_q))); // R5
   AST_DONE_STICKY : assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !start_i) |=> done_q); // R6
   AST_START_CLEARS : assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (!done_q && !err_q && !rdy_q)); // R8
   AST_DONE_ENDS : assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (st_q == ST_OFF)); // R6

endmodule

// File: rtl/pgmc_collect.sv
module pgmc_collect
   import pgmc_pkg::*;
#(
   parameter int          CW_W       = 32,
   parameter int          FLAG_BIT   = 31,
   parameter int          DATA_W     = 20,
   parameter int          DATA_LSB   = 11,
   parameter int          ERR_CNT_W  = 3,
   parameter int          MAX_FIX    = 2,
   parameter logic [31:0] IDLE_WORD  = 32'h7A89C197,
   parameter bit          IDLE_EXACT = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic                 cw_valid_i,
   input  logic [CW_W-1:0]      cw_i,
   input  logic                 sync_slot_i,
   input  logic [ERR_CNT_W-1:0] err_cnt_i,
   input  logic                 uncorr_i,
   output logic [DATA_W-1:0]    msg_data_o,
   output logic                 msg_rdy_o,
   output logic                 msg_err_o,
   output logic                 done_o
);

   localparam int DATA_MSB = DATA_LSB + DATA_W - 1;

   generate
      if (FLAG_BIT >= CW_W) begin : g_bad_flag
         $error("pgmc_collect: FLAG_BIT outside the codeword");
      end
      if (DATA_MSB >= FLAG_BIT) begin : g_bad_field
         $error("pgmc_collect: data field overlaps the flag bit");
      end
      if (CW_W > 32) begin : g_bad_width
         $error("pgmc_collect: CW_W above the idle constant width");
      end
      if (MAX_FIX >= (1 << ERR_CNT_W)) begin : g_bad_fix
         $error("pgmc_collect: MAX_FIX does not fit the error count");
      end
   endgenerate

   cw_kind_t          kind;
   logic              bad;
   logic [DATA_W-1:0] field;

   assign field = cw_i[DATA_LSB +: DATA_W];

   pgmc_classify #(
      .CW_W(CW_W), .FLAG_BIT(FLAG_BIT),
      .IDLE_WORD(IDLE_WORD), .IDLE_EXACT(IDLE_EXACT)
   ) i_classify (
      .valid_i(cw_valid_i), .sync_i(sync_slot_i), .cw_i(cw_i), .kind_o(kind)
   );

   pgmc_err_judge #(.ERR_CNT_W(ERR_CNT_W), .MAX_FIX(MAX_FIX)) i_judge (
      .cnt_i(err_cnt_i), .uncorr_i(uncorr_i), .bad_o(bad)
   );

   pgmc_ctrl #(.DATA_W(DATA_W)) i_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .kind_i(kind), .bad_i(bad), .field_i(field),
      .data_o(msg_data_o), .rdy_o(msg_rdy_o),
      .err_o(msg_err_o), .done_o(done_o)
   );

   AST_RDY_FROM_STROBE : assert property (@(posedge clk) disable iff (!rst_n)
      msg_rdy_o |-> $past(cw_valid_i)); // R9
   AST_RDY_NOT_SYNC : assert property (@(posedge clk) disable iff (!rst_n)
      msg_rdy_o |-> !$past(sync_slot_i)); // R7
   AST_RDY_FLAG_SET : assert property (@(posedge clk) disable iff (!rst_n)
      msg_rdy_o |-> $past(cw_i[FLAG_BIT])); // R3
   AST_DATA_HOLD : assert property (@(posedge clk) disable iff (!rst_n)
      (!msg_rdy_o && $past(rst_n)) |-> $stable(msg_data_o)); // R3

endmodule

// File: tb/test_pgmc_collect.sv
module test_pgmc_collect;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        cw_valid_i = 1'b0;
   logic [31:0] cw_i = '0;
   logic        sync_slot_i = 1'b0;
   logic [2:0]  err_cnt_i = '0;
   logic        uncorr_i = 1'b0;
   logic [19:0] msg_data_o;
   logic        msg_rdy_o, msg_err_o, done_o;

   int    n_chk = 0, n_fail = 0;
   string req = "R1";
   bit    ended = 1'b0;

   // behavioural reference
   bit        m_act = 0, m_rdy = 0, m_err = 0, m_done = 0;
   bit [19:0] m_data = '0;

   always #5 clk = ~clk;

   pgmc_collect i_pgmc_collect (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .cw_valid_i(cw_valid_i),
      .cw_i(cw_i), .sync_slot_i(sync_slot_i), .err_cnt_i(err_cnt_i),
      .uncorr_i(uncorr_i), .msg_data_o(msg_data_o), .msg_rdy_o(msg_rdy_o),
      .msg_err_o(msg_err_o), .done_o(done_o)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         m_act = 0; m_rdy = 0; m_err = 0; m_done = 0; m_data = '0;
      end else begin
         m_rdy = 0;
         if (start_i) begin
            m_act = 1; m_err = 0; m_done = 0;
         end else if (m_act && cw_valid_i && !sync_slot_i) begin
            if (cw_i[31]) begin
               if (!m_err) begin
                  m_data = cw_i[30:11];
                  m_rdy  = 1;
                  m_err  = uncorr_i || (err_cnt_i > 3'd2);
               end
            end else begin
               m_done = 1; m_act = 0;
            end
         end
      end
   end

   task automatic chk(input string what, input logic [19:0] act, input logic [19:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (!ended) begin
         chk("data", msg_data_o, m_data);
         chk("rdy", {19'd0, msg_rdy_o}, {19'd0, m_rdy});
         chk("err", {19'd0, msg_err_o}, {19'd0, m_err});
         chk("done", {19'd0, done_o}, {19'd0, m_done});
      end
   end

   function automatic logic [31:0] mw(input logic [19:0] d);
      return {1'b1, d, 11'h2B5};
   endfunction

   task automatic word(input logic [31:0] w, input bit sy, input logic [2:0] c, input bit u);
      cw_valid_i = 1; cw_i = w; sync_slot_i = sy; err_cnt_i = c; uncorr_i = u;
      @(negedge clk);
      cw_valid_i = 0; cw_i = 32'hFFFF_FFFF; sync_slot_i = 0; err_cnt_i = 0; uncorr_i = 0;
   endtask

   task automatic pulse_start();
      start_i = 1; @(negedge clk); start_i = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      req = "R1";
      idle(3);
      rst_n = 1;
      idle(1);
      req = "R2";                                     // before any start
      word(mw(20'hABCDE), 0, 0, 0); idle(1);
      word(32'h0000_1234, 0, 0, 0); idle(1);
      req = "R8"; pulse_start(); idle(1);
      req = "R3";
      word(mw(20'h12345), 0, 0, 0);
      word(mw(20'hFEDCB), 0, 1, 0);
      word(mw(20'h00001), 0, 2, 0); idle(1);
      word(mw(20'h80000), 0, 0, 0); idle(2);
      req = "R9";
      cw_i = mw(20'h55555); idle(3);
      req = "R7";
      word(32'h0000_0000, 1, 0, 0);                   // would end if not skipped
      word(mw(20'h77777), 1, 0, 0);
      word(mw(20'h33333), 0, 0, 0); idle(1);
      req = "R4";
      word(mw(20'hBAD00), 0, 3, 0); idle(1);
      req = "R5";
      word(mw(20'h11111), 0, 0, 0);
      word(mw(20'h22222), 0, 1, 0); idle(1);
      req = "R6";
      word(32'h1234_5678, 0, 0, 0); idle(2);          // address word ends
      req = "R2";
      word(mw(20'h44444), 0, 0, 0); idle(1);
      req = "R8"; pulse_start(); idle(1);
      req = "R4";
      word(mw(20'h0F0F0), 0, 1, 1); idle(1);          // uncorrectable
      req = "R8"; pulse_start();
      req = "R4";
      word(mw(20'h0AAAA), 0, 7, 0); idle(1);
      req = "R8"; pulse_start();
      word(mw(20'h0C0C0), 0, 2, 0);
      req = "R6";
      word(32'h7A89C197, 0, 0, 0); idle(1);           // idle word ends
      word(mw(20'h99999), 0, 0, 0); idle(1);
      req = "R8";
      start_i = 1; cw_valid_i = 1; cw_i = mw(20'h66666); @(negedge clk);
      start_i = 0; cw_valid_i = 0; idle(1);
      word(mw(20'h24680), 0, 0, 0); idle(2);
      req = "R1";
      rst_n = 0; idle(2); rst_n = 1; idle(1);
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!ended) begin
         ended = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule